// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupts

This block controls one port of up to eight general-purpose I/O pins through a small register-mapped bus. Each pin has its own 32-byte register window. The window holds a packed configuration byte, a debounce threshold, the filtered input level, a driver-release control, the output level and an interrupt-clear strobe. A pin can work as an input or as an output. When it is an output, its driver can still be held released, so the pad is left undriven.

Each pin samples its pad through a two-flop synchronizer. An optional debounce filter then counts in milliseconds, using a tick that a clock prescaler produces. Next comes an interrupt detector, which can work on level, on single edge or on both edges, with a polarity choice. Pending interrupts are latched per pin. A port status register sits just past the last pin window and shows the pending bits of the pins whose interrupt is enabled. The OR of those bits drives a single interrupt line.

Bus reads are combinational from the address. Writes take effect at the clock edge where the request and write strobe are sampled high. All registers are 8 bits wide.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Pin n's registers sit at byte address n*0x20 plus offset. The configuration byte at offset 0x00 reads back as written in bits [6:0]. Its fields are: bit0 pin enable, bit1 output direction, bits[3:2] trigger type, bit4 polarity, bit5 debounce enable, bit6 interrupt enable. A write to one pin leaves the other pins unchanged.
- R2: Offset 0x04 holds an 8-bit debounce threshold in milliseconds that reads back as written. Offset 0x08 bit0 reads the filtered pad level. Without debounce, a pad change shows there after three clock edges.
- R3: pad_oe_o of a pin is high only when the pin is enabled, set as an output, and its release bit (offset 0x0C bit0) is clear.
- R4: pad_o of a pin equals offset 0x10 bit0 while the pin drives, and is 0 otherwise.
- R5: Trigger type 1 is level. Polarity 1 is active-high and polarity 0 is active-low. The pending bit stays set while the active level lasts, even across a clear.
- R6: Trigger type 2 is single edge. Polarity 1 latches on rising edges only, and polarity 0 latches on falling edges only.
- R7: Trigger type 3 latches on both rising and falling edges, whatever the polarity bit holds.
- R8: An edge-latched pending bit holds until a write to the pin's offset 0x14. A new hit in the same cycle as the clear keeps the bit set.
- R9: Trigger type 0, or a cleared pin-enable bit, never sets the pending bit.
- R10: The status register at address NUM_PINS*0x20 shows pending AND interrupt-enable, one bit per pin. irq_o is the OR of those bits. A pin whose interrupt enable is clear still keeps its pending bit, and that bit appears once the enable is set.
- R11: With debounce enabled and a threshold T > 0, the filtered level changes only after the synchronized input has differed from it for T prescaler ticks. A tick comes every TICK_DIV clocks. A threshold of 0 passes the input straight through.
- R12: After reset, all configuration bytes, thresholds and output values are 0. Release bits are 1. Pending bits are 0, and irq_o and pad_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | AW ($clog2(NUM_PINS*32)+1) | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| pad_i | input | NUM_PINS | Raw pad levels |
| pad_o | output | NUM_PINS | Output levels |
| pad_oe_o | output | NUM_PINS | Output drive enables |
| irq_o | output | 1 | Aggregated port interrupt |

## Verification
A pad change reaches the synchronizer output after two edges. It reaches the filtered level and the input register after the third edge. An edge detected there sets the pending bit at the fourth edge, so status and irq_o follow four edges after the pad change. Register writes, clears, and pad_o and pad_oe_o changes appear one edge after the write strobe is sampled. The bench's reference model advances at every rising edge and holds the same latencies as state. It compares irq_o, pad_o, pad_oe_o and the status read at every falling edge. The directed reads wait well past the worst-case latency, or the debounce window, before they check absolute values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    TRIG_NONE   = 2'd0,
    TRIG_LEVEL  = 2'd1,
    TRIG_SINGLE = 2'd2,
    TRIG_DOUBLE = 2'd3
  } trig_e;

  // bit6..bit0
  typedef struct packed {
    logic  ien;
    logic  deb_en;
    logic  pol;
    trig_e trig;
    logic  dir_out;
    logic  en;
  } pin_cfg_t;

  localparam logic [4:0] OFF_CFG  = 5'h00;
  localparam logic [4:0] OFF_THR  = 5'h04;
  localparam logic [4:0] OFF_IN   = 5'h08;
  localparam logic [4:0] OFF_FLT  = 5'h0C;
  localparam logic [4:0] OFF_OVAL = 5'h10;
  localparam logic [4:0] OFF_CLR  = 5'h14;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int TICK_DIV = 250000,
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r11_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TICK_DIV > 1 && tick_o) |=> !tick_o);
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       pad_i,
  input  logic       we_i,
  input  logic [4:0] off_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       pend_o,
  output logic       ien_o,
  output logic       pad_o,
  output logic       pad_oe_o
);
  pin_cfg_t   cfg_q;
  logic [7:0] thr_q, cnt_q;
  logic       flt_q, oval_q;
  logic       s1_q, s2_q, lvl_q, prev_q, pend_q;
  logic       clr_w, bypass, hit;

  assign clr_w  = we_i && (off_i == OFF_CLR);
  assign bypass = !cfg_q.deb_en || (thr_q == 8'd0);

  // register file
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      thr_q  <= '0;
      flt_q  <= 1'b1;
      oval_q <= 1'b0;
    end else if (we_i) begin
      unique case (off_i)
        OFF_CFG:  cfg_q  <= pin_cfg_t'(wdata_i[6:0]);
        OFF_THR:  thr_q  <= wdata_i;
        OFF_FLT:  flt_q  <= wdata_i[0];
        OFF_OVAL: oval_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  // synchronizer + debounce
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q   <= pad_i;
      s2_q   <= s1_q;
      prev_q <= lvl_q;
      if (bypass) begin
        lvl_q <= s2_q;
        cnt_q <= '0;
      end else if (s2_q == lvl_q) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q + 8'd1 >= thr_q) begin
          lvl_q <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 8'd1;
        end
      end
    end
  end

  // trigger detect
  always_comb begin
    hit = 1'b0;
    if (cfg_q.en) begin
      unique case (cfg_q.trig)
        TRIG_LEVEL:  hit = (lvl_q == cfg_q.pol);
        TRIG_SINGLE: hit = cfg_q.pol ? (lvl_q && !prev_q) : (!lvl_q && prev_q);
        TRIG_DOUBLE: hit = (lvl_q != prev_q);
        default:     hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !clr_w) || hit;
  end

  always_comb begin
    unique case (off_i)
      OFF_CFG:  rdata_o = {1'b0, cfg_q};
      OFF_THR:  rdata_o = thr_q;
      OFF_IN:   rdata_o = {7'd0, lvl_q};
      OFF_FLT:  rdata_o = {7'd0, flt_q};
      OFF_OVAL: rdata_o = {7'd0, oval_q};
      default:  rdata_o = 8'd0;
    endcase
  end

  assign pend_o   = pend_q;
  assign ien_o    = cfg_q.ien;
  assign pad_oe_o = cfg_q.en && cfg_q.dir_out && !flt_q;
  assign pad_o    = oval_q && pad_oe_o;

  a_r2_bypass_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.deb_en |=> (lvl_q == $past(s2_q)));
  a_r11_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.deb_en && thr_q != 8'd0 && !tick_i && !we_i) |=> $stable(lvl_q));
  a_r5_level_keeps_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.en && cfg_q.trig == TRIG_LEVEL && lvl_q == cfg_q.pol) |=> pend_q);
  a_r6_rise_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.en && cfg_q.trig == TRIG_SINGLE && cfg_q.pol && lvl_q && !prev_q) |=> pend_q);
  a_r7_any_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.en && cfg_q.trig == TRIG_DOUBLE && lvl_q != prev_q) |=> pend_q);
  a_r8_pending_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_w) |=> pend_q);
  a_r9_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.en && !pend_q) |=> !pend_q);
  a_r3_release_blocks_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_q |-> !pad_oe_o);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NUM_PINS = 8,
  parameter int TICK_DIV = 250000,
  localparam int AW = $clog2(NUM_PINS * 32) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic                irq_o
);
  localparam int WIN_W = AW - 5;
  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_PINS * 32);

  logic                tick;
  logic [NUM_PINS-1:0] pend, ien, status;
  logic [7:0]          pin_rd [NUM_PINS];

  gpio_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .pad_i    (pad_i[p]),
      .we_i     (req_i && we_i && (addr_i[AW-1:5] == WIN_W'(p))),
      .off_i    (addr_i[4:0]),
      .wdata_i  (wdata_i),
      .rdata_o  (pin_rd[p]),
      .pend_o   (pend[p]),
      .ien_o    (ien[p]),
      .pad_o    (pad_o[p]),
      .pad_oe_o (pad_oe_o[p])
    );
  end

  assign status = pend & ien;
  assign irq_o  = |status;

  always_comb begin
    rdata_o = 8'd0;
    if (addr_i == STAT_ADDR) begin
      rdata_o = 8'(status);
    end else begin
      for (int p = 0; p < NUM_PINS; p++)
        if (addr_i[AW-1:5] == WIN_W'(p)) rdata_o = pin_rd[p];
    end
  end

  a_r10_masked_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ien) == '0) |-> !irq_o);
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  localparam int N = 8;
  localparam int DIV = 4;
  localparam int AW = 9;
  localparam logic [AW-1:0] STAT = 9'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req = 0, we = 0;
  logic [AW-1:0] addr = STAT;
  logic [7:0] wdata = 0, rdata;
  logic [N-1:0] pad = '0, pad_o, pad_oe;
  logic irq;

  gpio_port_ctrl #(.NUM_PINS(N), .TICK_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad), .pad_o(pad_o),
    .pad_oe_o(pad_oe), .irq_o(irq));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [6:0] m_cfg [N];
  int         m_thr [N], m_cnt [N];
  bit         m_flt [N], m_oval [N], m_s1 [N], m_s2 [N], m_lvl [N], m_prev [N], m_pend [N];
  int         m_tcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tcnt = 0;
      for (int p = 0; p < N; p++) begin
        m_cfg[p] = 0; m_thr[p] = 0; m_cnt[p] = 0; m_flt[p] = 1; m_oval[p] = 0;
        m_s1[p] = 0; m_s2[p] = 0; m_lvl[p] = 0; m_prev[p] = 0; m_pend[p] = 0;
      end
    end else begin
      bit tk;
      tk = (m_tcnt == DIV - 1);
      m_tcnt = tk ? 0 : m_tcnt + 1;
      for (int p = 0; p < N; p++) begin
        bit hit, sel, clr, nl;
        int nc, off;
        hit = 0;
        if (m_cfg[p][0]) begin
          case (m_cfg[p][3:2])
            2'd1: hit = (m_lvl[p] == m_cfg[p][4]);
            2'd2: hit = m_cfg[p][4] ? (m_lvl[p] && !m_prev[p]) : (!m_lvl[p] && m_prev[p]);
            2'd3: hit = (m_lvl[p] != m_prev[p]);
            default: hit = 0;
          endcase
        end
        sel = req && we && (int'(addr) / 32 == p);
        off = int'(addr) % 32;
        clr = sel && off == 20;
        nl = m_lvl[p]; nc = m_cnt[p];
        if (!m_cfg[p][5] || m_thr[p] == 0) begin nl = m_s2[p]; nc = 0; end
        else if (m_s2[p] == m_lvl[p]) nc = 0;
        else if (tk) begin
          if (m_cnt[p] + 1 >= m_thr[p]) begin nl = m_s2[p]; nc = 0; end
          else nc = m_cnt[p] + 1;
        end
        m_pend[p] = (m_pend[p] && !clr) || hit;
        m_prev[p] = m_lvl[p]; m_lvl[p] = nl; m_cnt[p] = nc;
        m_s2[p] = m_s1[p]; m_s1[p] = pad[p];
        if (sel) begin
          if (off == 0)  m_cfg[p] = wdata[6:0];
          if (off == 4)  m_thr[p] = int'(wdata);
          if (off == 12) m_flt[p] = wdata[0];
          if (off == 16) m_oval[p] = wdata[0];
        end
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] st, oe, po;
      for (int p = 0; p < N; p++) begin
        st[p] = m_pend[p] && m_cfg[p][6];
        oe[p] = m_cfg[p][0] && m_cfg[p][1] && !m_flt[p];
        po[p] = oe[p] && m_oval[p];
      end
      check("R10 irq_o", 32'(irq), 32'(|st));
      check("R3 pad_oe_o", 32'(pad_oe), 32'(oe));
      check("R4 pad_o", 32'(pad_o), 32'(po));
      if (addr == STAT) check("R10 status", 32'(rdata), 32'(st));
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1 req = 1; we = 1; addr = AW'(a); wdata = 8'(d);
    @(posedge clk); #1 req = 0; we = 0; addr = STAT;
  endtask

  task automatic rd_exp(input int a, input int exp, input string tag);
    @(posedge clk); #1 addr = AW'(a);
    @(negedge clk); check(tag, 32'(rdata), 32'(exp));
    #1 addr = STAT;
  endtask

  task automatic set_pad(input int p, input bit v);
    @(posedge clk); #1 pad[p] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3); #1 rst_n = 1;
    // R12 reset state
    rd_exp(32'h000, 0, "R12 cfg after reset");
    rd_exp(32'h00C, 1, "R12 release bit after reset");
    rd_exp(32'h100, 0, "R12 status after reset");
    @(negedge clk); check("R12 irq_o after reset", 32'(irq), 0);
    check("R12 pad_oe_o after reset", 32'(pad_oe), 0);
    // R1 windows and field readback
    wr(32'h060, 32'h55);
    rd_exp(32'h060, 32'h55, "R1 pin3 cfg readback");
    rd_exp(32'h040, 0, "R1 pin2 untouched");
    wr(32'h060, 0);
    // R2 threshold and input
    wr(32'h0A4, 32'hAB);
    rd_exp(32'h0A4, 32'hAB, "R2 threshold readback");
    wr(32'h000, 32'h01);
    set_pad(0, 1); idle(4);
    rd_exp(32'h008, 1, "R2 input level");
    // R3 / R4 drive
    wr(32'h020, 32'h03); wr(32'h030, 1);
    @(negedge clk); check("R3 released driver off", 32'(pad_oe[1]), 0);
    wr(32'h02C, 0);
    @(negedge clk); check("R3 driver on", 32'(pad_oe[1]), 1);
    check("R4 drives high", 32'(pad_o[1]), 1);
    wr(32'h030, 0);
    @(negedge clk); check("R4 drives low", 32'(pad_o[1]), 0);
    wr(32'h020, 32'h01);
    @(negedge clk); check("R3 input dir off", 32'(pad_oe[1]), 0);
    // R6 / R8 single edge on pin2
    wr(32'h040, 32'h59);
    set_pad(2, 1); idle(6);
    rd_exp(32'h100, 32'h04, "R6 rising latched");
    wr(32'h054, 1); idle(1);
    rd_exp(32'h100, 0, "R8 clear");
    set_pad(2, 0); idle(6);
    rd_exp(32'h100, 0, "R6 falling ignored pol1");
    wr(32'h040, 32'h49);
    set_pad(2, 1); idle(6);
    rd_exp(32'h100, 0, "R6 rising ignored pol0");
    set_pad(2, 0); idle(6);
    rd_exp(32'h100, 32'h04, "R6 falling latched");
    idle(20);
    rd_exp(32'h100, 32'h04, "R8 held until clear");
    wr(32'h054, 0); idle(1);
    rd_exp(32'h100, 0, "R8 cleared");
    // R5 level on pin4
    wr(32'h080, 32'h55);
    set_pad(4, 1); idle(6);
    rd_exp(32'h100, 32'h10, "R5 active-high pending");
    wr(32'h094, 1); idle(2);
    rd_exp(32'h100, 32'h10, "R5 persists across clear");
    set_pad(4, 0); idle(6);
    wr(32'h094, 1); idle(2);
    rd_exp(32'h100, 0, "R5 released");
    wr(32'h080, 32'h45); idle(3);
    rd_exp(32'h100, 32'h10, "R5 active-low pending");
    wr(32'h080, 0); wr(32'h094, 1); idle(2);
    rd_exp(32'h100, 0, "R5 disabled and cleared");
    // R7 double edge on pin6
    wr(32'h0C0, 32'h5D);
    set_pad(6, 1); idle(6);
    rd_exp(32'h100, 32'h40, "R7 rise");
    wr(32'h0D4, 1); idle(2);
    set_pad(6, 0); idle(6);
    rd_exp(32'h100, 32'h40, "R7 fall");
    wr(32'h0D4, 1); idle(2);
    // R9 no trigger / disabled
    wr(32'h0E0, 32'h41);
    set_pad(7, 1); idle(6);
    rd_exp(32'h100, 0, "R9 type none");
    wr(32'h0E0, 32'h4C);
    set_pad(7, 0); idle(6);
    rd_exp(32'h100, 0, "R9 pin disabled");
    // R10 masking on pin5
    wr(32'h0A0, 32'h0D);
    set_pad(5, 1); idle(6);
    rd_exp(32'h100, 0, "R10 masked status");
    @(negedge clk); check("R10 masked irq_o", 32'(irq), 0);
    wr(32'h0A0, 32'h4D);
    rd_exp(32'h100, 32'h20, "R10 pending kept when unmasked");
    @(negedge clk); check("R10 irq_o raised", 32'(irq), 1);
    wr(32'h0B4, 1); idle(2);
    // R11 debounce on pin3
    wr(32'h064, 3); wr(32'h060, 32'h21);
    set_pad(3, 1); idle(5); set_pad(3, 0); idle(30);
    rd_exp(32'h068, 0, "R11 glitch rejected");
    set_pad(3, 1); idle(8);
    rd_exp(32'h068, 0, "R11 not yet settled");
    idle(30);
    rd_exp(32'h068, 1, "R11 settled");
    wr(32'h064, 0);
    set_pad(3, 0); idle(4);
    rd_exp(32'h068, 0, "R11 zero threshold bypass");
    idle(4);
    finish_run();
  end
endmodule